// File: doc/BRIEF.md
# Program Counter Update Unit

This block holds the program counter of a small load/store processor and works out its next value each cycle. A shared adder sums the current count with a selected addend. The addend is either a constant one or the operand word, which carries the instruction literal or a value from the second bus. Absolute loads for jumps bypass the adder. Two condition-code bits from the arithmetic unit decide whether a conditional branch adds its offset or just steps.

The unit is driven by the instruction decoder. Each cycle the decoder presents a three-bit command code, an operand word and the two flags. Whenever the count is written, the new value appears on the fetch address output, and a fetch request pulses for one cycle so the instruction memory reads that word. A halt input freezes the counter and blocks fetches.

Top module: `pc_update_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count is set to 0 and `fetch_req` is set to 1. After reset is released, `fetch_addr` reads 0 and `fetch_req` reads 1 until the first active edge.
- R2: Command code 1 (step) writes count+1, wrapping modulo 2^PC_W.
- R3: Command code 2 (absolute jump) writes the operand word as the new count.
- R4: Command code 3 (register jump) writes the operand word, which is the source-register value on the second bus, as the new count.
- R5: Command code 4 (branch on zero) with `cc0` = 0 writes count + operand. The operand is taken as a two's-complement offset of PC_W bits, and the sum wraps modulo 2^PC_W.
- R6: Command code 4 with `cc0` = 1 writes count+1.
- R7: Command code 5 (branch on negative) writes count + operand when `cc1` = 1 and count+1 when `cc1` = 0.
- R8: On every active edge that writes the count, `fetch_addr` takes the new value and `fetch_req` is 1 for the following cycle only. If the next edge does not write the count, `fetch_req` returns to 0.
- R9: Command code 0 and the unused codes 6 and 7 leave the count unchanged and give `fetch_req` = 0.
- R10: When `halt` is 1 at an edge, the count is unchanged and `fetch_req` is 0 whatever the command.
- R11: The flags have no effect on commands 1, 2 and 3. Command 4 ignores `cc1`, and command 5 ignores `cc0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Freezes the count and blocks fetch requests |
| cmd | input | 3 | Update command: 0 hold, 1 step, 2 absolute jump, 3 register jump, 4 branch on zero, 5 branch on negative, 6/7 hold |
| operand | input | PC_W | Literal or second-bus value: jump target or branch offset |
| cc0 | input | 1 | Zero flag (0 means the last result was zero) |
| cc1 | input | 1 | Negative flag (1 means the last result was negative) |
| fetch_addr | output | PC_W | Current count, used as the instruction-memory address |
| fetch_req | output | 1 | One-cycle fetch strobe after each write of the count |

## Verification
Every result sits one register away from its inputs. The command, operand, flags and halt sampled at a rising edge show up on `fetch_addr` and `fetch_req` just after that same edge. The bench drives inputs on the falling edge and samples one time unit after the next rising edge, so each comparison covers exactly one command. The only result not tied to a command is the reset value. It is checked after reset is released and before the first active edge, when the strobe must still be high.

// File: rtl/pcu_pkg.sv
// Package: shared command encoding for the program counter update unit.
// Assumes the decoder emits exactly one of these codes per cycle.
package pcu_pkg;
    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_HOLD = 3'd0,
        CMD_STEP = 3'd1,
        CMD_JABS = 3'd2,
        CMD_JREG = 3'd3,
        CMD_BRZ  = 3'd4,
        CMD_BRN  = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } pcu_cmd_e;
endpackage

// File: rtl/pcu_branch_eval.sv
// Module: decides whether a conditional branch is taken from the flags.
// Assumes cc0 = 0 flags a zero result and cc1 = 1 flags a negative result.
// Non-branch commands never report a taken branch.
module pcu_branch_eval
    import pcu_pkg::*;
(
    input  pcu_cmd_e cmd,
    input  logic     cc0,
    input  logic     cc1,
    output logic     taken
);
    // Condition select: each branch looks only at its own flag.
    always_comb begin
        case (cmd)
            CMD_BRZ: taken = ~cc0;
            CMD_BRN: taken = cc1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcu_next_sel.sv
// Module: next-address datapath. A selector picks +1 or the operand as the
// adder's second input; absolute jumps bypass the adder. Also flags whether
// the command writes the count at all. Sums wrap modulo 2^PC_W.
module pcu_next_sel
    import pcu_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc,
    input  pcu_cmd_e        cmd,
    input  logic [PC_W-1:0] operand,
    input  logic            taken,
    output logic [PC_W-1:0] next_pc,
    output logic            update
);
    localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

    logic [PC_W-1:0] addend;
    logic [PC_W-1:0] sum;
    logic            absolute;

    // Addend selector: branch offset only for a taken branch.
    always_comb addend = taken ? operand : ONE;

    // Shared adder.
    always_comb sum = pc + addend;

    // Command classification: absolute load and write enable.
    always_comb begin
        absolute = 1'b0;
        update   = 1'b0;
        case (cmd)
            CMD_STEP, CMD_BRZ, CMD_BRN: update = 1'b1;
            CMD_JABS, CMD_JREG: begin
                update   = 1'b1;
                absolute = 1'b1;
            end
            default: update = 1'b0;
        endcase
    end

    // Final mux: operand for jumps, adder result otherwise.
    always_comb next_pc = absolute ? operand : sum;
endmodule

// File: rtl/pcu_pc_reg.sv
// Module: program counter register and fetch strobe. Reset is synchronous,
// active low: count 0 and strobe high so address 0 is fetched. Halt blocks
// both writes and strobes.
module pcu_pc_reg #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic            update,
    input  logic [PC_W-1:0] next_pc,
    output logic [PC_W-1:0] pc_q,
    output logic            req_q
);
    logic write_en;

    // Write enable: a command asks for an update and the unit is not halted.
    always_comb write_en = update & ~halt;

    // State update: count and one-cycle fetch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            req_q <= 1'b1;
        end else begin
            req_q <= write_en;
            if (write_en) pc_q <= next_pc;
        end
    end

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(pc_q)); // R10
    AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !req_q); // R10
    AST_REQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_q) |-> req_q); // R8
endmodule

// File: rtl/pc_update_unit.sv
// Module: top of the program counter update unit. Combines branch
// evaluation, the next-address datapath and the count register. Inputs are
// sampled at the rising edge; outputs are registered.
module pc_update_unit
    import pcu_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic [2:0]      cmd,
    input  logic [PC_W-1:0] operand,
    input  logic            cc0,
    input  logic            cc1,
    output logic [PC_W-1:0] fetch_addr,
    output logic            fetch_req
);
    pcu_cmd_e        cmd_e;
    logic            taken;
    logic            update;
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] pc_q;
    logic            req_q;

    // Command decode: the full code space is enumerated.
    always_comb cmd_e = pcu_cmd_e'(cmd);

    pcu_branch_eval u_branch (
        .cmd   (cmd_e),
        .cc0   (cc0),
        .cc1   (cc1),
        .taken (taken)
    );

    pcu_next_sel #(.PC_W(PC_W)) u_next (
        .pc      (pc_q),
        .cmd     (cmd_e),
        .operand (operand),
        .taken   (taken),
        .next_pc (next_pc),
        .update  (update)
    );

    pcu_pc_reg #(.PC_W(PC_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .halt    (halt),
        .update  (update),
        .next_pc (next_pc),
        .pc_q    (pc_q),
        .req_q   (req_q)
    );

    // Output drive: fetch address is the live count.
    always_comb begin
        fetch_addr = pc_q;
        fetch_req  = req_q;
    end

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd2 && !halt) |=> fetch_addr == $past(operand)); // R3
    AST_BRZ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd4 && cc0 && !halt) |=> fetch_addr == $past(fetch_addr) + 1'b1); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 3'd0 && !halt) |=> ($stable(fetch_addr) && !fetch_req)); // R9
endmodule

// File: tb/tb_pc_update_unit.sv
module tb_pc_update_unit;
    localparam int PC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            halt = 1'b0;
    logic [2:0]      cmd = 3'd0;
    logic [PC_W-1:0] operand = '0;
    logic            cc0 = 1'b1;
    logic            cc1 = 1'b0;
    logic [PC_W-1:0] fetch_addr;
    logic            fetch_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [PC_W-1:0] m_pc;

    pc_update_unit #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .halt(halt), .cmd(cmd), .operand(operand),
        .cc0(cc0), .cc1(cc1), .fetch_addr(fetch_addr), .fetch_req(fetch_req)
    );

    always #2 clk = ~clk;

    function automatic logic [PC_W-1:0] exp_next(logic [PC_W-1:0] pc, logic [2:0] c,
                                                 logic [PC_W-1:0] op, logic z, logic n);
        case (c)
            3'd1: return pc + 1'b1;
            3'd2, 3'd3: return op;
            3'd4: return z ? pc + 1'b1 : pc + op;
            3'd5: return n ? pc + op : pc + 1'b1;
            default: return pc;
        endcase
    endfunction

    function automatic bit exp_write(logic [2:0] c, logic h);
        return !h && (c >= 3'd1 && c <= 3'd5);
    endfunction

    function automatic string tag_of(logic [2:0] c, logic h);
        if (h) return "R10";
        case (c)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5/R6";
            3'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(logic h, logic [2:0] c, logic [PC_W-1:0] op,
                        logic z, logic n, string tag);
        bit w;
        @(negedge clk);
        halt = h; cmd = c; operand = op; cc0 = z; cc1 = n;
        w = exp_write(c, h);
        if (w) m_pc = exp_next(m_pc, c, op, z, n);
        @(posedge clk);
        #1;
        chk({tag, " addr"}, fetch_addr, m_pc);
        chk({tag, " R8 req"}, {{(PC_W-1){1'b0}}, fetch_req}, {{(PC_W-1){1'b0}}, w});
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        m_pc = '0;
        chk("R1 addr", fetch_addr, '0);
        chk("R1 req", {{(PC_W-1){1'b0}}, fetch_req}, {{(PC_W-1){1'b0}}, 1'b1});

        step(0, 3'd1, 16'h0,    1, 0, "R2 step");
        step(0, 3'd2, 16'hFFFF, 1, 0, "R3 jump top");
        step(0, 3'd1, 16'h0,    1, 0, "R2 wrap");
        step(0, 3'd3, 16'h0100, 1, 0, "R4 jreg");
        step(0, 3'd4, 16'hFFFD, 0, 0, "R5 back");
        step(0, 3'd4, 16'h0040, 1, 0, "R6 fallthru");
        step(0, 3'd5, 16'h0010, 1, 1, "R7 taken");
        step(0, 3'd5, 16'h0010, 0, 0, "R7 fallthru");
        step(0, 3'd0, 16'h1234, 0, 1, "R9 hold");
        step(0, 3'd7, 16'h1234, 0, 1, "R9 code7");
        step(0, 3'd6, 16'h5555, 0, 1, "R9 code6");
        step(1, 3'd2, 16'hABCD, 0, 1, "R10 halt jump");
        step(1, 3'd1, 16'h0,    0, 0, "R10 halt step");
        step(0, 3'd2, 16'h0200, 0, 1, "R11 jump flags");
        step(0, 3'd1, 16'h0,    0, 1, "R11 step flags");
        step(0, 3'd4, 16'h0008, 1, 1, "R11 brz ignores cc1");
        step(0, 3'd5, 16'h0008, 0, 0, "R11 brn ignores cc0");
        step(0, 3'd2, 16'hFFFE, 0, 0, "R3 near top");
        step(0, 3'd5, 16'h0005, 0, 1, "R7 wrap forward");

        for (int i = 0; i < 400; i++) begin
            logic       h;
            logic [2:0] c;
            h = ($urandom % 8) == 0;
            c = 3'($urandom % 8);
            step(h, c, 16'($urandom), 1'($urandom), 1'($urandom), tag_of(c, h));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule